// File: doc/BRIEF.md
# FIFO Level and Transaction Interrupt Status Unit

This block turns the state of a bus master's transmit and receive FIFOs, together with the outcome pulses of its transfer sequencer, into one 32-bit interrupt status word and one interrupt line. Six level events follow FIFO occupancy:

- the empty, nearly-empty and full conditions of the transmit FIFO;
- the empty, nearly-full and full conditions of the receive FIFO.

The nearly-empty and nearly-full events are compared against programmable thresholds.

Five transaction events are sticky. Each stays set until software writes a one to its position in the clear port:

- transmit overrun;
- transfer done;
- done without stop;
- arbitration lost;
- bus error.

A mask register gates the raw word into a masked word. The interrupt output is the registered OR of the masked word.

The unit also owns the two FIFO flush request bits. Software sets a flush bit, and the bit stays set until the FIFO logic reports that the flush has finished. Software polls these bits before it touches a FIFO again. The FIFO storage and the register decoder sit outside. They connect through the plain write strobes and data buses of this block.

Top module: `fifo_irq_status`

## Requirements
- R1: While `rst` is high at a clock edge, `raw_stat`, `irq_mask`, `irq` and `flush_busy` all become zero.
- R2: One clock after the inputs are presented, the transmit level bits of `raw_stat` take these values:
  - bit 0 is 1 when `tx_level` is 0;
  - bit 1 is 1 when `tx_level` is at most the effective transmit threshold;
  - bit 2 is 1 when `tx_level` equals `FIFO_DEPTH`.
- R3: One clock after the inputs are presented, the receive level bits of `raw_stat` take these values:
  - bit 4 is 1 when `rx_level` is 0;
  - bit 5 is 1 when `rx_level` is greater than or equal to the effective receive threshold;
  - bit 6 is 1 when `rx_level` equals `FIFO_DEPTH`.
- R4: The effective threshold is the programmed 4-bit value, limited to `FIFO_DEPTH/2 - 1`. The limit is 7 for a depth of 16.
- R5: Bit 3 (transmit overrun) is set only by `tx_push` while `tx_level` equals `FIFO_DEPTH`. A push into a FIFO that is not full leaves it clear.
- R6: Each sticky event sets its bit one clock after its input pulse. The positions are: done at 19, arbitration lost at 24, bus error at 25. The bit then holds until a `clr_we` write has a one at that position. If a set and a clear arrive in the same cycle, the set wins.
- R7: Bit 28 (done without stop) is set by `xfer_done_nostop` when `HAS_NOSTOP` is 1. When `HAS_NOSTOP` is 0 it always reads zero.
- R8: A `mask_we` write loads `irq_mask` with bits 31:29 forced to zero. `masked_stat` equals `raw_stat & irq_mask`.
- R9: `irq` is 1 exactly one clock after a cycle in which `masked_stat` is non-zero. It is 0 one clock after a cycle in which `masked_stat` is zero.
- R10: `flush_busy[k]` (0 = transmit, 1 = receive) is set by a `flush_we` write with a one in `flush_wdata[k]`. It stays set until `flush_done[k]`, and then clears. If a set and a done arrive in the same cycle, the set wins.
- R11: Positions that are not listed above always read zero in `raw_stat`. These include 7–18, 20–23, 26, 27 and 29–31.
- R12: Writing ones to the level positions (0–2, 4–6) of the clear port has no effect. Those bits keep following occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_level | input | CNT_W | Transmit FIFO occupancy |
| rx_level | input | CNT_W | Receive FIFO occupancy |
| tx_thresh | input | 4 | Programmed transmit nearly-empty threshold |
| rx_thresh | input | 4 | Programmed receive nearly-full threshold |
| tx_push | input | 1 | Write strobe into the transmit FIFO |
| xfer_done | input | 1 | Transfer completed with stop (pulse) |
| xfer_done_nostop | input | 1 | Transfer completed without stop (pulse) |
| arb_lost | input | 1 | Arbitration lost (pulse) |
| bus_err | input | 1 | Bus error (pulse) |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 32 | Mask register write data |
| clr_we | input | 1 | Clear port write strobe |
| clr_wdata | input | 32 | Write-one-to-clear data |
| flush_we | input | 1 | Flush request write strobe |
| flush_wdata | input | 2 | Flush requests to set (bit 0 transmit, bit 1 receive) |
| flush_done | input | 2 | Flush finished, per FIFO |
| raw_stat | output | 32 | Raw interrupt status |
| irq_mask | output | 32 | Mask register contents |
| masked_stat | output | 32 | Raw status AND mask |
| irq | output | 1 | Combined registered interrupt |
| flush_busy | output | 2 | Flush requests still running |

## Verification
The bench sweeps every occupancy from empty to full against every 4-bit threshold on both FIFOs. Thresholds above the limit are where a design without the clamp would report nearly-full too late, or nearly-empty too early. An inverted comparison would also show up at the threshold boundary itself.

A set and a clear in the same cycle is tried for both the sticky events and the flush bits. A design that gives the clear priority would lose an event or drop a flush that was just requested.

The bench follows the interrupt line cycle by cycle after an event and after its clear. An output that is not registered would rise, or fall, one clock early.

A second instance without the done-without-stop variant must keep bit 28 at zero under the same pulse. Pushes into a FIFO that is not full must not raise the overrun bit.

// File: rtl/fis_pkg.sv
package fis_pkg;
  localparam int STAT_W   = 32;
  localparam int B_TXE    = 0;
  localparam int B_TXNE   = 1;
  localparam int B_TXF    = 2;
  localparam int B_TXOV   = 3;
  localparam int B_RXE    = 4;
  localparam int B_RXNF   = 5;
  localparam int B_RXF    = 6;
  localparam int B_MDONE  = 19;
  localparam int B_ARB    = 24;
  localparam int B_BERR   = 25;
  localparam int B_NOSTOP = 28;

  localparam logic [STAT_W-1:0] CLR_ALLOWED = 32'h131F_007F;
  localparam logic [STAT_W-1:0] MASK_IMPL   = 32'h1FFF_FFFF;

  localparam int N_STICKY = 5;
  localparam int STICKY_POS [N_STICKY] = '{B_TXOV, B_MDONE, B_ARB, B_BERR, B_NOSTOP};

  // limit a programmed threshold to half the FIFO depth minus one
  function automatic logic [3:0] clamp_thresh(input logic [3:0] th, input int depth);
    int lim;
    lim = depth / 2 - 1;
    if (int'(th) > lim) return 4'(lim);
    return th;
  endfunction
endpackage

// File: rtl/fis_level.sv
module fis_level #(
  parameter int DEPTH     = 16,
  parameter int CNT_W     = 5,
  parameter bit NEAR_FULL = 1'b0
) (
  input  logic [CNT_W-1:0] level,
  input  logic [3:0]       thresh,
  output logic             empty,
  output logic             near,
  output logic             full
);
  assign empty = (level == '0);
  assign full  = (int'(level) == DEPTH);

  generate
    if (NEAR_FULL) begin : g_near_full
      assign near = (int'(level) >= int'(thresh));
    end else begin : g_near_empty
      assign near = (int'(level) <= int'(thresh));
    end
  endgenerate
endmodule

// File: rtl/fis_sticky_bit.sv
module fis_sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  p_set_sticks_r6: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q);
  p_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (q && !clr_i) |=> q);
endmodule

// File: rtl/fis_flush.sv
module fis_flush #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] done_i,
  output logic [N-1:0] busy
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                  busy[k] <= 1'b0;
      else if (we && set_i[k])  busy[k] <= 1'b1;
      else if (done_i[k])       busy[k] <= 1'b0;
    end

    p_flush_fall_r10: assert property (@(posedge clk) disable iff (rst)
      $fell(busy[k]) |-> $past(done_i[k]));
    p_flush_set_r10: assert property (@(posedge clk) disable iff (rst)
      (we && set_i[k]) |=> busy[k]);
  end
endmodule

// File: rtl/fifo_irq_status.sv
module fifo_irq_status
  import fis_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter bit HAS_NOSTOP = 1'b1,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  tx_level,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic [3:0]        tx_thresh,
  input  logic [3:0]        rx_thresh,
  input  logic              tx_push,
  input  logic              xfer_done,
  input  logic              xfer_done_nostop,
  input  logic              arb_lost,
  input  logic              bus_err,
  input  logic              mask_we,
  input  logic [31:0]       mask_wdata,
  input  logic              clr_we,
  input  logic [31:0]       clr_wdata,
  input  logic              flush_we,
  input  logic [1:0]        flush_wdata,
  input  logic [1:0]        flush_done,
  output logic [31:0]       raw_stat,
  output logic [31:0]       irq_mask,
  output logic [31:0]       masked_stat,
  output logic              irq,
  output logic [1:0]        flush_busy
);
  logic [3:0] tx_eff, rx_eff;
  logic tx_e, tx_ne, tx_f, rx_e, rx_nf, rx_f;
  logic [2:0] tx_lv_q, rx_lv_q;
  logic [N_STICKY-1:0] sset, sq;

  assign tx_eff = clamp_thresh(tx_thresh, FIFO_DEPTH);
  assign rx_eff = clamp_thresh(rx_thresh, FIFO_DEPTH);

  fis_level #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .NEAR_FULL(1'b0)) u_tx_lvl (
    .level(tx_level), .thresh(tx_eff), .empty(tx_e), .near(tx_ne), .full(tx_f));
  fis_level #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .NEAR_FULL(1'b1)) u_rx_lvl (
    .level(rx_level), .thresh(rx_eff), .empty(rx_e), .near(rx_nf), .full(rx_f));

  // level events follow occupancy, one register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_lv_q <= '0;
      rx_lv_q <= '0;
    end else begin
      tx_lv_q <= {tx_f, tx_ne, tx_e};
      rx_lv_q <= {rx_f, rx_nf, rx_e};
    end
  end

  // sticky sources, in the order of STICKY_POS
  assign sset[0] = tx_push && (int'(tx_level) == FIFO_DEPTH);
  assign sset[1] = xfer_done;
  assign sset[2] = arb_lost;
  assign sset[3] = bus_err;
  assign sset[4] = xfer_done_nostop;

  for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
    if (STICKY_POS[i] == B_NOSTOP && !HAS_NOSTOP) begin : g_absent
      assign sq[i] = 1'b0;
    end else begin : g_present
      fis_sticky_bit u_bit (
        .clk  (clk),
        .rst  (rst),
        .set_i(sset[i]),
        .clr_i(clr_we && clr_wdata[STICKY_POS[i]] && CLR_ALLOWED[STICKY_POS[i]]),
        .q    (sq[i])
      );
    end
  end

  always_comb begin
    raw_stat = '0;
    raw_stat[B_TXE]  = tx_lv_q[0];
    raw_stat[B_TXNE] = tx_lv_q[1];
    raw_stat[B_TXF]  = tx_lv_q[2];
    raw_stat[B_RXE]  = rx_lv_q[0];
    raw_stat[B_RXNF] = rx_lv_q[1];
    raw_stat[B_RXF]  = rx_lv_q[2];
    for (int i = 0; i < N_STICKY; i++) raw_stat[STICKY_POS[i]] = sq[i];
  end

  always_ff @(posedge clk) begin
    if (rst)          irq_mask <= '0;
    else if (mask_we) irq_mask <= mask_wdata & MASK_IMPL;
  end

  assign masked_stat = raw_stat & irq_mask;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |masked_stat;
  end

  fis_flush #(.N(2)) u_flush (
    .clk(clk), .rst(rst), .we(flush_we), .set_i(flush_wdata),
    .done_i(flush_done), .busy(flush_busy));

  p_rxnf_r3: assert property (@(posedge clk) disable iff (rst)
    (int'(rx_level) >= int'(clamp_thresh(rx_thresh, FIFO_DEPTH))) |=> raw_stat[B_RXNF]);
  p_txne_r2: assert property (@(posedge clk) disable iff (rst)
    (int'(tx_level) > int'(clamp_thresh(tx_thresh, FIFO_DEPTH))) |=> !raw_stat[B_TXNE]);
  p_irq_high_r9: assert property (@(posedge clk) disable iff (rst)
    (masked_stat != '0) |=> irq);
  p_irq_low_r9: assert property (@(posedge clk) disable iff (rst)
    (masked_stat == '0) |=> !irq);
  p_ovr_needs_full_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(raw_stat[B_TXOV]) |-> $past(tx_push && int'(tx_level) == FIFO_DEPTH));
endmodule

// File: tb/sim_fifo_irq_status.sv
module sim_fifo_irq_status;
  localparam int DEPTH = 16;
  localparam int CW = 5;
  localparam logic [31:0] STK = 32'h1308_0008;

  logic clk = 1'b0;
  logic rst;
  logic [CW-1:0] tx_level, rx_level;
  logic [3:0] tx_thresh, rx_thresh;
  logic tx_push, xfer_done, xfer_done_nostop, arb_lost, bus_err;
  logic mask_we, clr_we, flush_we;
  logic [31:0] mask_wdata, clr_wdata;
  logic [1:0] flush_wdata, flush_done;
  logic [31:0] raw0, msk0, mst0, raw1, msk1, mst1;
  logic irq0, irq1;
  logic [1:0] fb0, fb1;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  fifo_irq_status #(.FIFO_DEPTH(DEPTH), .HAS_NOSTOP(1'b1)) u0 (
    .clk, .rst, .tx_level, .rx_level, .tx_thresh, .rx_thresh, .tx_push,
    .xfer_done, .xfer_done_nostop, .arb_lost, .bus_err, .mask_we, .mask_wdata,
    .clr_we, .clr_wdata, .flush_we, .flush_wdata, .flush_done,
    .raw_stat(raw0), .irq_mask(msk0), .masked_stat(mst0), .irq(irq0), .flush_busy(fb0));

  fifo_irq_status #(.FIFO_DEPTH(DEPTH), .HAS_NOSTOP(1'b0)) u1 (
    .clk, .rst, .tx_level, .rx_level, .tx_thresh, .rx_thresh, .tx_push,
    .xfer_done, .xfer_done_nostop, .arb_lost, .bus_err, .mask_we, .mask_wdata,
    .clr_we, .clr_wdata, .flush_we, .flush_wdata, .flush_done,
    .raw_stat(raw1), .irq_mask(msk1), .masked_stat(mst1), .irq(irq1), .flush_busy(fb1));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lim(input int th);
    return (th > DEPTH / 2 - 1) ? DEPTH / 2 - 1 : th;
  endfunction

  initial begin
    #3_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1;
    tx_level = '0; rx_level = '0; tx_thresh = '0; rx_thresh = '0;
    tx_push = 0; xfer_done = 0; xfer_done_nostop = 0; arb_lost = 0; bus_err = 0;
    mask_we = 0; clr_we = 0; flush_we = 0;
    mask_wdata = '0; clr_wdata = '0; flush_wdata = '0; flush_done = '0;
    repeat (3) tick();
    // R1 reset state
    chk("R1 raw", raw0, 32'h0);
    chk("R1 mask", msk0, 32'h0);
    chk("R1 irq", {31'b0, irq0}, 32'h0);
    chk("R1 flush", {30'b0, fb0}, 32'h0);
    rst = 1'b0;

    // R2 R4 transmit sweep
    for (int c = 0; c <= DEPTH; c++) begin
      for (int t = 0; t < 16; t++) begin
        tx_level = CW'(c);
        tx_thresh = 4'(t);
        tick();
        chk(t > 7 ? "R4 tx clamp" : "R2 tx level", {29'b0, raw0[2:0]},
            {29'b0, (c == DEPTH), (c <= lim(t)), (c == 0)});
      end
    end
    // R3 R4 receive sweep
    for (int c = 0; c <= DEPTH; c++) begin
      for (int t = 0; t < 16; t++) begin
        rx_level = CW'(c);
        rx_thresh = 4'(t);
        tick();
        chk(t > 7 ? "R4 rx clamp" : "R3 rx level", {29'b0, raw0[6:4]},
            {29'b0, (c == DEPTH), (c >= lim(t)), (c == 0)});
      end
    end
    tx_level = 5; rx_level = 3; tx_thresh = 2; rx_thresh = 4;
    tick();

    // R5 overrun only when full
    tx_push = 1; tick(); tx_push = 0;
    chk("R5 push not full", raw0 & STK, 32'h0);
    tx_level = CW'(DEPTH); tx_push = 1; tick(); tx_push = 0;
    chk("R5 push full", raw0 & STK, 32'h0000_0008);
    tick();
    chk("R5 overrun sticky", raw0 & STK, 32'h0000_0008);

    // R6 R7 sticky events
    xfer_done = 1; arb_lost = 1; bus_err = 1; xfer_done_nostop = 1;
    tick();
    xfer_done = 0; arb_lost = 0; bus_err = 0; xfer_done_nostop = 0;
    chk("R6 events set", raw0 & STK, 32'h1308_0008);
    chk("R7 variant off", raw1 & STK, 32'h0308_0008);
    tick();
    chk("R6 events hold", raw0 & STK, 32'h1308_0008);
    // R11 undefined positions
    chk("R11 reserved zero", raw0 & ~32'h1308_007F, 32'h0);
    chk("R11 reserved zero u1", raw1 & ~32'h1308_007F, 32'h0);

    clr_we = 1; clr_wdata = 32'h0100_0000; tick(); clr_we = 0;
    chk("R6 clear one", raw0 & STK, 32'h1208_0008);
    xfer_done = 1; clr_we = 1; clr_wdata = 32'h0008_0000; tick();
    xfer_done = 0; clr_we = 0;
    chk("R6 set beats clear", raw0 & STK, 32'h1208_0008);
    clr_we = 1; clr_wdata = 32'hFFFF_FFFF; tick(); clr_we = 0;
    chk("R6 clear all", raw0 & STK, 32'h0);

    // R12 level bits ignore clear
    tx_level = 0; tick();
    clr_we = 1; clr_wdata = 32'h0000_007F; tick(); clr_we = 0;
    chk("R12 level unaffected", {31'b0, raw0[0]}, 32'h1);

    // R8 mask
    mask_we = 1; mask_wdata = 32'hFFFF_FFFF; tick(); mask_we = 0;
    chk("R8 mask reserved", msk0, 32'h1FFF_FFFF);
    chk("R8 masked and", mst0, raw0 & 32'h1FFF_FFFF);

    // R9 registered interrupt
    mask_we = 1; mask_wdata = 32'h0100_0000; tick(); mask_we = 0;
    tick();
    chk("R9 idle", {31'b0, irq0}, 32'h0);
    arb_lost = 1; tick(); arb_lost = 0;
    chk("R8 masked event", mst0, 32'h0100_0000);
    chk("R9 latency", {31'b0, irq0}, 32'h0);
    tick();
    chk("R9 irq high", {31'b0, irq0}, 32'h1);
    clr_we = 1; clr_wdata = 32'h0100_0000; tick(); clr_we = 0;
    chk("R9 irq falls late", {31'b0, irq0}, 32'h1);
    tick();
    chk("R9 irq low", {31'b0, irq0}, 32'h0);

    // R10 flush control
    flush_we = 1; flush_wdata = 2'b01; tick(); flush_we = 0;
    chk("R10 flush set", {30'b0, fb0}, 32'h1);
    repeat (3) tick();
    chk("R10 flush held", {30'b0, fb0}, 32'h1);
    flush_done = 2'b01; tick(); flush_done = 2'b00;
    chk("R10 flush done", {30'b0, fb0}, 32'h0);
    flush_we = 1; flush_wdata = 2'b10; tick();
    flush_done = 2'b10; tick();
    flush_we = 0; flush_done = 2'b00;
    chk("R10 set beats done", {30'b0, fb0}, 32'h2);
    flush_done = 2'b11; tick(); flush_done = 2'b00;
    chk("R10 both done", {30'b0, fb0}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule